// File: doc/BRIEF.md
# Home and Index Input Conditioner

This block sits between the home (origin) switch, the encoder index pin and the sequencing logic of a motion pulse controller. Both pins arrive asynchronously and are first brought into the reference clock domain. The home input then receives a selectable polarity and, optionally, a glitch filter that insists on a minimum number of consecutive active reference clocks. A qualified home event is held in a latch until the motor is reported stopped, so a short pass over the switch is never lost.

The index input is polarity-corrected by an edge-select bit and its qualifying edges are counted against a programmed target. The target field holds the wanted edge count minus one. When the last edge arrives, a single-cycle completion pulse is produced, and further edges are ignored until the next operation start. Both inputs only take effect while the 7-bit operation mode selects one of the eight homing or index-count operations. Live, polarity-corrected pin status is always available.

Top module: `hix_conditioner`

## Requirements
- R1: The pins affect `home_latched` and `index_reached` only while `op_mode` is one of 0010000, 0010010, 0010101, 0100100, 0011000, 0011010, 0011101, 0101100 (binary, bit 6 first); any other value leaves both outputs at 0.
- R2: Once a home pulse is qualified, `home_latched` stays 1 after the pin returns inactive, for as long as `motor_stopped` stays 0.
- R3: `motor_stopped` high clears `home_latched` on the next clock edge and restarts the index edge count from zero.
- R4: With `home_filter_en` = 1, a home pulse of FILT_LEN consecutive active cycles sets the latch; one of FILT_LEN-1 cycles does not.
- R5: With `home_filter_en` = 0, a home pulse of 2 active cycles sets the latch; a 1-cycle pulse does not.
- R6: `home_active_high` = 1 makes a high home pin active; 0 makes a low home pin active.
- R7: `index_rising` = 1 counts rising index edges; 0 counts falling index edges; the other edge is never counted.
- R8: With `index_target` = N (0 to 15), `index_reached` pulses high for exactly one cycle on the (N+1)-th qualifying edge after `op_start`; later edges produce no pulse until the next `op_start`.
- R9: `home_status` is 1 when the home pin is at its active level and `index_status` is 1 when the index pin is high with `index_rising` = 1 or low with `index_rising` = 0, each three clocks after the pin changes.
- R10: An `op_start` pulse resets the index edge count and re-arms the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| home_pin | input | 1 | Raw asynchronous home switch |
| index_pin | input | 1 | Raw asynchronous encoder index |
| op_mode | input | 7 | Decoded operation mode |
| op_start | input | 1 | One-cycle pulse at the start of an operation |
| motor_stopped | input | 1 | Motor is not moving |
| home_active_high | input | 1 | Home polarity: 1 active-high, 0 active-low |
| index_rising | input | 1 | Index edge: 1 rising, 0 falling |
| home_filter_en | input | 1 | Enable the home glitch filter |
| index_target | input | CNT_W | Wanted index edges minus one |
| home_latched | output | 1 | Latched home event |
| index_reached | output | 1 | One-cycle index-count completion pulse |
| home_status | output | 1 | Live polarity-corrected home pin |
| index_status | output | 1 | Live polarity-corrected index pin |

## Verification
The bench builds the block with FILT_LEN = 10, SYNC_STAGES = 2 and CNT_W = 4. The short filter length puts both sides of the filter threshold, a 9-cycle pulse and a 10-cycle pulse, within a few dozen cycles, while the default counter width lets the full target range from 0 to 15 be reached. The 2-cycle versus 1-cycle boundary of the unfiltered path and both index edge polarities are driven directly.

// File: rtl/hix_pkg.sv
package hix_pkg;

  localparam logic [6:0] MODE_HOME_RET_POS  = 7'b0010000;
  localparam logic [6:0] MODE_LEAVE_POS     = 7'b0010010;
  localparam logic [6:0] MODE_SEARCH_POS    = 7'b0010101;
  localparam logic [6:0] MODE_IDX_CNT_POS   = 7'b0100100;
  localparam logic [6:0] MODE_HOME_RET_NEG  = 7'b0011000;
  localparam logic [6:0] MODE_LEAVE_NEG     = 7'b0011010;
  localparam logic [6:0] MODE_SEARCH_NEG    = 7'b0011101;
  localparam logic [6:0] MODE_IDX_CNT_NEG   = 7'b0101100;

  // True when the mode makes use of the home and index pins.
  function automatic logic mode_uses_pins(input logic [6:0] m);
    logic hit;
    case (m)
      MODE_HOME_RET_POS, MODE_LEAVE_POS, MODE_SEARCH_POS, MODE_IDX_CNT_POS,
      MODE_HOME_RET_NEG, MODE_LEAVE_NEG, MODE_SEARCH_NEG, MODE_IDX_CNT_NEG:
        hit = 1'b1;
      default:
        hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/hix_sync.sv
module hix_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= '0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hix_home_filter.sv
module hix_home_filter #(
  parameter int FILT_LEN = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic active_high,
  input  logic filt_en,
  input  logic arm,
  input  logic clear,
  output logic latched,
  output logic status
);

  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          act;
  logic          prev_act;
  logic [CW-1:0] run_cnt;
  logic          qual;

  assign act = active_high ? pin_s : ~pin_s;

  // Consecutive-active-cycle counter, saturating at LAST.
  always_ff @(posedge clk) begin
    if (rst || !act)        run_cnt <= '0;
    else if (run_cnt != LAST) run_cnt <= run_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) prev_act <= 1'b0;
    else     prev_act <= act;
  end

  assign qual = act && (filt_en ? (run_cnt == LAST) : prev_act);

  always_ff @(posedge clk) begin
    if (rst || clear)    latched <= 1'b0;
    else if (arm && qual) latched <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= 1'b0;
    else     status <= act;
  end

  // R2: latch holds while no stop is seen
  a_r2_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (latched && !clear) |=> latched);

  // R5: unfiltered acceptance needs the pin active in the cycle before too
  a_r5_two_cycle_min: assert property (@(posedge clk) disable iff (rst)
    ($rose(latched) && !$past(filt_en)) |-> $past(status));

  // R4: filtered acceptance needs the full run of active cycles
  a_r4_full_run: assert property (@(posedge clk) disable iff (rst)
    ($rose(latched) && $past(filt_en)) |-> ($past(run_cnt) == LAST));

endmodule

// File: rtl/hix_index_counter.sv
module hix_index_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_s,
  input  logic             rising,
  input  logic             arm,
  input  logic             restart,
  input  logic [CNT_W-1:0] target,
  output logic             done,
  output logic             status
);

  logic             act;
  logic             prev_act;
  logic             edge_hit;
  logic [CNT_W-1:0] cnt;
  logic             finished;

  assign act      = rising ? pin_s : ~pin_s;
  assign edge_hit = act & ~prev_act;
  assign status   = prev_act;

  always_ff @(posedge clk) begin
    if (rst) prev_act <= 1'b0;
    else     prev_act <= act;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt      <= '0;
      finished <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (arm && !finished && edge_hit) begin
        if (cnt == target) begin
          done     <= 1'b1;
          finished <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: a completion pulse is caused by a detected edge
  a_r8_needs_edge: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(edge_hit));

  // R8: no further pulse once finished
  a_r8_quiet_after: assert property (@(posedge clk) disable iff (rst)
    finished |=> !done);

  // R3 and R10: restart empties the count
  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !done));

endmodule

// File: rtl/hix_conditioner.sv
module hix_conditioner #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 80,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             home_pin,
  input  logic             index_pin,
  input  logic [6:0]       op_mode,
  input  logic             op_start,
  input  logic             motor_stopped,
  input  logic             home_active_high,
  input  logic             index_rising,
  input  logic             home_filter_en,
  input  logic [CNT_W-1:0] index_target,
  output logic             home_latched,
  output logic             index_reached,
  output logic             home_status,
  output logic             index_status
);

  logic       mode_ok;
  logic       arm;
  logic [1:0] pins_s;

  assign mode_ok = hix_pkg::mode_uses_pins(op_mode);
  assign arm     = mode_ok & ~motor_stopped;

  hix_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({index_pin, home_pin}),
    .q   (pins_s)
  );

  hix_home_filter #(.FILT_LEN(FILT_LEN)) u_home (
    .clk         (clk),
    .rst         (rst),
    .pin_s       (pins_s[0]),
    .active_high (home_active_high),
    .filt_en     (home_filter_en),
    .arm         (arm),
    .clear       (motor_stopped),
    .latched     (home_latched),
    .status      (home_status)
  );

  hix_index_counter #(.CNT_W(CNT_W)) u_index (
    .clk     (clk),
    .rst     (rst),
    .pin_s   (pins_s[1]),
    .rising  (index_rising),
    .arm     (arm),
    .restart (op_start | motor_stopped),
    .target  (index_target),
    .done    (index_reached),
    .status  (index_status)
  );

  // R1: a home event is only taken while a pin-using mode is selected
  a_r1_home_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(home_latched) |-> $past(mode_ok));

  // R1: completion only under a pin-using mode
  a_r1_index_gate: assert property (@(posedge clk) disable iff (rst)
    index_reached |-> $past(mode_ok));

  // R3: stop clears the latch on the next edge
  a_r3_stop_clears: assert property (@(posedge clk) disable iff (rst)
    motor_stopped |=> !home_latched);

endmodule

// File: tb/tb_hix_conditioner.sv
module tb_hix_conditioner;

  localparam int FL = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       home_pin = 1'b0;
  logic       index_pin = 1'b0;
  logic [6:0] op_mode = 7'b0;
  logic       op_start = 1'b0;
  logic       motor_stopped = 1'b1;
  logic       home_active_high = 1'b1;
  logic       index_rising = 1'b1;
  logic       home_filter_en = 1'b0;
  logic [3:0] index_target = 4'd0;
  logic       home_latched, index_reached, home_status, index_status;

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  int dbl_cnt  = 0;
  logic prev_done = 1'b0;

  always #2.5 clk = ~clk;

  hix_conditioner #(.SYNC_STAGES(2), .FILT_LEN(FL), .CNT_W(4)) dut (
    .clk(clk), .rst(rst), .home_pin(home_pin), .index_pin(index_pin),
    .op_mode(op_mode), .op_start(op_start), .motor_stopped(motor_stopped),
    .home_active_high(home_active_high), .index_rising(index_rising),
    .home_filter_en(home_filter_en), .index_target(index_target),
    .home_latched(home_latched), .index_reached(index_reached),
    .home_status(home_status), .index_status(index_status)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (index_reached) done_cnt++;
      if (index_reached && prev_done) dbl_cnt++;
    end
    prev_done = index_reached;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic begin_op(input logic [6:0] m);
    op_mode = m;
    motor_stopped = 1'b0;
    op_start = 1'b1;
    cyc(1);
    op_start = 1'b0;
    cyc(1);
  endtask

  task automatic stop_op();
    motor_stopped = 1'b1;
    cyc(2);
  endtask

  task automatic home_pulse(input int len);
    home_pin = home_active_high;
    cyc(len);
    home_pin = ~home_active_high;
    cyc(8);
  endtask

  task automatic idx_edge();
    index_pin = index_rising;
    cyc(4);
    index_pin = ~index_rising;
    cyc(4);
  endtask

  task automatic t_reset();
    chk("R3 reset latch", home_latched, 0);
    chk("R8 reset done", index_reached, 0);
    chk("R9 reset home status", home_status, 0);
  endtask

  task automatic t_unfiltered();
    home_active_high = 1'b1; home_pin = 1'b0; home_filter_en = 1'b0;
    begin_op(7'b0010000);
    home_pulse(1);
    chk("R5 one-cycle rejected", home_latched, 0);
    home_pulse(2);
    chk("R5 two-cycle accepted", home_latched, 1);
    cyc(10);
    chk("R2 latch held after pin low", home_latched, 1);
    motor_stopped = 1'b1;
    cyc(1);
    chk("R3 stop clears latch", home_latched, 0);
    cyc(1);
  endtask

  task automatic t_filtered();
    home_filter_en = 1'b1;
    begin_op(7'b0011101);
    home_pulse(FL - 1);
    chk("R4 short pulse rejected", home_latched, 0);
    home_pulse(FL);
    chk("R4 full pulse accepted", home_latched, 1);
    stop_op();
    chk("R3 cleared", home_latched, 0);
    home_filter_en = 1'b0;
  endtask

  task automatic t_polarity();
    home_active_high = 1'b0; home_pin = 1'b1;
    cyc(5);
    chk("R9 inactive high pin, active-low", home_status, 0);
    begin_op(7'b0011010);
    home_pin = 1'b0;
    cyc(4);
    chk("R9 low pin seen active", home_status, 1);
    home_pin = 1'b1;
    cyc(6);
    chk("R6 active-low accepted", home_latched, 1);
    stop_op();
    home_active_high = 1'b1; home_pin = 1'b0;
    cyc(4);
    begin_op(7'b0010010);
    home_pin = 1'b1;
    cyc(1);
    home_pin = 1'b0;
    cyc(6);
    chk("R6 active-high one-cycle still rejected", home_latched, 0);
    stop_op();
  endtask

  task automatic t_mode_ignore();
    int base;
    begin_op(7'b0000000);
    home_pulse(5);
    chk("R1 home ignored in mode 0", home_latched, 0);
    begin_op(7'b0010001);
    home_pulse(5);
    chk("R1 home ignored in mode 0010001", home_latched, 0);
    index_rising = 1'b1; index_pin = 1'b0; index_target = 4'd0;
    cyc(4);
    begin_op(7'b1111111);
    base = done_cnt;
    idx_edge();
    chk("R1 index ignored", done_cnt - base, 0);
    stop_op();
  endtask

  task automatic t_index_count();
    int base;
    index_rising = 1'b1; index_pin = 1'b0; index_target = 4'd3;
    cyc(4);
    begin_op(7'b0100100);
    base = done_cnt;
    for (int i = 0; i < 3; i++) idx_edge();
    chk("R8 not yet after 3 edges", done_cnt - base, 0);
    idx_edge();
    chk("R8 done on 4th edge", done_cnt - base, 1);
    idx_edge(); idx_edge();
    chk("R8 later edges ignored", done_cnt - base, 1);
    index_target = 4'd0;
    begin_op(7'b0100100);
    idx_edge();
    chk("R10 restart, target 0 done on 1st edge", done_cnt - base, 2);
    index_target = 4'd15;
    begin_op(7'b0101100);
    for (int i = 0; i < 15; i++) idx_edge();
    chk("R8 target 15 not after 15", done_cnt - base, 2);
    idx_edge();
    chk("R8 target 15 done on 16th", done_cnt - base, 3);
    chk("R8 pulses single cycle", dbl_cnt, 0);
    stop_op();
  endtask

  task automatic t_index_stop();
    int base;
    index_rising = 1'b1; index_pin = 1'b0; index_target = 4'd2;
    begin_op(7'b0100100);
    base = done_cnt;
    idx_edge(); idx_edge();
    motor_stopped = 1'b1;
    cyc(2);
    motor_stopped = 1'b0;
    cyc(1);
    idx_edge(); idx_edge();
    chk("R3 stop restarted count", done_cnt - base, 0);
    idx_edge();
    chk("R3 done after 3 fresh edges", done_cnt - base, 1);
    stop_op();
  endtask

  task automatic t_falling();
    int base;
    index_rising = 1'b0; index_pin = 1'b1; index_target = 4'd0;
    cyc(5);
    chk("R9 idle high pin inactive for falling", index_status, 0);
    begin_op(7'b0101100);
    base = done_cnt;
    index_pin = 1'b0;
    cyc(4);
    chk("R9 low pin active for falling", index_status, 1);
    cyc(2);
    chk("R7 falling edge counted", done_cnt - base, 1);
    begin_op(7'b0101100);
    index_pin = 1'b1;
    cyc(6);
    chk("R7 rising edge not counted", done_cnt - base, 1);
    index_pin = 1'b0;
    cyc(6);
    chk("R7 next falling edge counted", done_cnt - base, 2);
    stop_op();
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_unfiltered();
    t_filtered();
    t_polarity();
    t_mode_ignore();
    t_index_count();
    t_index_stop();
    t_falling();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule